// File: doc/BRIEF.md
# Stack Load/Store Byte-Lane Unit

This block sits between a stack machine's execute stage and a single-ported data memory whose word is as wide as the datapath. It handles the two memory head opcodes. A load takes the address from the top of the data stack and returns the value that replaces it. A store takes a data value and an address and returns the address, which stays on the stack.

The datapath width `DW` may be 16, 32, 64 or 128 bits. Each access carries a 4-bit transfer code. That code sets the access size and, for loads, whether the value is sign-extended or zero-extended. A code that the configured width does not support is flagged as illegal. An access that is not aligned to its own size is flagged as misaligned. Neither kind reaches the memory.

Byte lanes are little-endian: the low address bits pick the first byte lane inside the memory word. The memory interface is single-cycle. The request is presented combinationally in the cycle it arrives, read data returns on the next clock edge, and the response to the stack is valid one cycle after the request.

Top module: `stack_lane_unit`

## Requirements
- R1: A load with code 0, 2, 4 or 6 returns 1, 2, 4 or 8 bytes, sign-extended to `DW`. Codes 1, 3, 5 and 7 return the same sizes zero-extended. Code 8 returns 16 bytes. Bytes are taken little-endian starting at byte lane `addr mod (DW/8)`.
- R2: A load code is legal only when it is at most 2·log2(`DW`/8). With the default `DW`=32, codes 0 to 4 are legal.
- R3: A legal, aligned store with code k (0 to 4) asserts exactly 2^k consecutive bits of `mem_be`, starting at lane `addr mod (DW/8)`, with `mem_we`=1. The low byte of `req_wdata` is placed in that first lane, and the following bytes go in ascending lanes.
- R4: A store code is legal only when it is at most log2(`DW`/8). With `DW`=32, codes 0 to 2 are legal.
- R5: For an illegal code, `mem_en` stays 0 and `mem_be` is all zero. One cycle later the response has `rsp_illegal`=1, `rsp_misaligned`=0, and for a load `rsp_data`=0.
- R6: A legal access whose address is not a multiple of its byte size keeps `mem_en` at 0 and `mem_be` at zero. One cycle later the response has `rsp_misaligned`=1, and for a load `rsp_data`=0.
- R7: Every request gives `rsp_valid`=1 in the next cycle. For a legal, aligned load, `rsp_data` is the extended memory value.
- R8: A store's response carries its address, zero-extended to `DW`, in `rsp_data`.
- R9: While `rst_n` is low at a clock edge, `rsp_valid`, `rsp_illegal` and `rsp_misaligned` are 0 after that edge.
- R10: Without `req_valid`, `mem_en` and `mem_we` are 0 and `mem_be` is zero. A load sets `mem_we`=0. `mem_addr` is the request address with its byte-lane bits cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_type | input | 4 | Transfer code |
| req_addr | input | AW | Byte address (top of stack) |
| req_wdata | input | DW | Store data (second stack element) |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | AW | Word-aligned memory address |
| mem_be | output | DW/8 | Byte-lane enables |
| mem_wdata | output | DW | Lane-aligned store data |
| mem_rdata | input | DW | Read word, valid the cycle after `mem_en` |
| rsp_valid | output | 1 | Response valid |
| rsp_data | output | DW | Value that goes back onto the stack |
| rsp_illegal | output | 1 | Transfer code illegal for `DW` |
| rsp_misaligned | output | 1 | Address not aligned to the access size |

## Verification
If a captured lane offset, size or extension flag is wrong, the next cycle's load result shows it at once as a shifted, truncated or wrongly extended value. If the legality or alignment decision is wrong, the same cycle shows it as byte enables on a request that should have been blocked, or as a missing strobe. A store whose lanes are misplaced stays invisible until a later load reads those bytes back. The random mix of stores and loads over a small memory is meant to close that gap within a few operations.

// File: rtl/lane_pkg.sv
// Shared types and decode helpers for the stack load/store lane unit.
// Assumes 4-bit transfer codes; size is carried as log2 of the byte count.
package lane_pkg;

    typedef struct packed {
        logic       legal;
        logic       misaligned;
        logic       sext;
        logic [2:0] size_log;
    } xfer_info_t;

    // Byte-count log2 for a load code: pairs share a size, code 8 is 16 bytes.
    function automatic logic [2:0] load_size_log(input logic [3:0] code);
        if (code[3]) return 3'd4;
        return {1'b0, code[2:1]};
    endfunction

endpackage

// File: rtl/lane_type_dec.sv
// Transfer-code decoder: legality against the datapath width, access size,
// extension kind and natural-alignment check.
// Assumes LOG = log2(bytes per word) and OFFW lane-offset bits (OFFW == LOG).
module lane_type_dec
    import lane_pkg::*;
#(
    parameter int LOG  = 2,
    parameter int OFFW = 2
) (
    input  logic            is_store,
    input  logic [3:0]      code,
    input  logic [OFFW-1:0] addr_low,
    output xfer_info_t      info
);
    localparam logic [3:0] LD_MAX = 4'(2 * LOG);
    localparam logic [3:0] ST_MAX = 4'(LOG);

    logic [2:0]      sz;
    logic            ok;
    logic [OFFW-1:0] amask;

    // Decode size, legality and alignment mask for the current code.
    always_comb begin
        sz    = is_store ? code[2:0] : load_size_log(code);
        ok    = is_store ? (code <= ST_MAX) : (code <= LD_MAX);
        amask = OFFW'((32'd1 << sz) - 32'd1);
        info.size_log   = sz;
        info.legal      = ok;
        info.sext       = !is_store && !code[3] && !code[0];
        info.misaligned = ok && (|(addr_low & amask));
    end
endmodule

// File: rtl/lane_store_align.sv
// Store-side lane steering: builds per-lane byte enables from offset and
// size, and shifts store data into its little-endian lanes.
// Assumes the caller gates en for illegal or misaligned accesses.
module lane_store_align #(
    parameter int DW   = 32,
    parameter int NB   = DW / 8,
    parameter int OFFW = 2
) (
    input  logic            en,
    input  logic [2:0]      size_log,
    input  logic [OFFW-1:0] off,
    input  logic [DW-1:0]   data,
    output logic [NB-1:0]   be,
    output logic [DW-1:0]   wdata
);
    int nbytes;
    int first;

    // Byte count and start lane as integers for lane comparison.
    always_comb begin
        nbytes = 1 << size_log;
        first  = int'(off);
    end

    // One enable per lane: inside [first, first + nbytes).
    for (genvar i = 0; i < NB; i++) begin : g_lane
        assign be[i] = en && (i >= first) && (i < first + nbytes);
    end

    // Move the low bytes of the data up to the start lane.
    always_comb begin
        wdata = data << {off, 3'b000};
    end
endmodule

// File: rtl/lane_load_extract.sv
// Load-side lane extraction: shifts the start lane down, masks to the
// access size and sign- or zero-extends; kill forces a zero result.
// Assumes size_log never exceeds log2(DW/8) when kill is low.
module lane_load_extract #(
    parameter int DW   = 32,
    parameter int OFFW = 2
) (
    input  logic            kill,
    input  logic            sext,
    input  logic [2:0]      size_log,
    input  logic [OFFW-1:0] off,
    input  logic [DW-1:0]   rdata,
    output logic [DW-1:0]   data
);
    localparam int IDXW = $clog2(DW);

    logic [DW-1:0] shifted;
    logic [DW-1:0] keep;
    logic          sbit;
    int            bits;

    // Align, mask and extend the addressed bytes.
    always_comb begin
        shifted = rdata >> {off, 3'b000};
        bits    = 8 << size_log;
        keep    = ~({DW{1'b1}} << bits);
        sbit    = shifted[IDXW'(bits - 1)];
        if (kill)
            data = '0;
        else
            data = (shifted & keep) | ((sext && sbit) ? ~keep : '0);
    end
endmodule

// File: rtl/stack_lane_unit.sv
// Stack load/store lane unit. Presents legal, aligned requests to a
// single-cycle memory the same cycle; returns the stack result one cycle
// later (loaded value for loads, the address for stores).
// Assumes AW <= DW and DW in {16, 32, 64, 128}; memory read data is valid
// the cycle after mem_en.
module stack_lane_unit
    import lane_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_store,
    input  logic [3:0]    req_type,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW/8-1:0] mem_be,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic          rsp_illegal,
    output logic          rsp_misaligned
);
    localparam int NB   = DW / 8;
    localparam int OFFW = $clog2(NB);
    localparam int LOG  = OFFW;

    xfer_info_t      info;
    logic            go;
    logic [OFFW-1:0] off;

    logic            store_q;
    logic            sext_q;
    logic [2:0]      size_q;
    logic [OFFW-1:0] off_q;
    logic [AW-1:0]   addr_q;
    logic [DW-1:0]   ld_data;

    assign off = req_addr[OFFW-1:0];

    lane_type_dec #(.LOG(LOG), .OFFW(OFFW)) u_dec (
        .is_store (req_store),
        .code     (req_type),
        .addr_low (off),
        .info     (info)
    );

    // Issue only legal, aligned requests.
    always_comb begin
        go       = req_valid && info.legal && !info.misaligned;
        mem_en   = go;
        mem_we   = go && req_store;
        mem_addr = {req_addr[AW-1:OFFW], {OFFW{1'b0}}};
    end

    lane_store_align #(.DW(DW), .NB(NB), .OFFW(OFFW)) u_st (
        .en       (go),
        .size_log (info.size_log),
        .off      (off),
        .data     (req_wdata),
        .be       (mem_be),
        .wdata    (mem_wdata)
    );

    // Capture response state for the cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid      <= 1'b0;
            rsp_illegal    <= 1'b0;
            rsp_misaligned <= 1'b0;
            store_q        <= 1'b0;
            sext_q         <= 1'b0;
            size_q         <= '0;
            off_q          <= '0;
            addr_q         <= '0;
        end else begin
            rsp_valid      <= req_valid;
            rsp_illegal    <= req_valid && !info.legal;
            rsp_misaligned <= req_valid && info.misaligned;
            store_q        <= req_store;
            sext_q         <= info.sext;
            size_q         <= info.size_log;
            off_q          <= off;
            addr_q         <= req_addr;
        end
    end

    lane_load_extract #(.DW(DW), .OFFW(OFFW)) u_ld (
        .kill     (rsp_illegal || rsp_misaligned || !rsp_valid),
        .sext     (sext_q),
        .size_log (size_q),
        .off      (off_q),
        .rdata    (mem_rdata),
        .data     (ld_data)
    );

    // Stack result: address for stores, extracted value for loads.
    always_comb begin
        if (rsp_valid && store_q)
            rsp_data = DW'(addr_q);
        else
            rsp_data = ld_data;
    end

    // R5
    illegal_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !info.legal) |-> (!mem_en && mem_be == '0));

    // R3
    be_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> ($countones(mem_be) == (1 << info.size_log)));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (!mem_en && !mem_we && mem_be == '0));

    // R7
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R8
    store_keeps_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_store) |=> (rsp_data == DW'($past(req_addr))));

    // R6
    misaligned_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_misaligned && !store_q) |-> (rsp_data == '0 && !rsp_illegal));

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!rsp_valid && !rsp_illegal && !rsp_misaligned));
endmodule

// File: tb/stack_lane_unit_test.sv
// Bench for stack_lane_unit at DW=32: directed corner cases then a seeded
// random mix of loads and stores over a 64-byte memory with a byte-level
// reference image.
module stack_lane_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int AW = 16;
    localparam int NB = DW / 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_store = 1'b0;
    logic [3:0]    req_type = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          mem_en, mem_we;
    logic [AW-1:0] mem_addr;
    logic [NB-1:0] mem_be;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic          rsp_valid, rsp_illegal, rsp_misaligned;
    logic [DW-1:0] rsp_data;

    logic [7:0] dmem [64];
    logic [7:0] refm [64];

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    stack_lane_unit #(.DW(DW), .AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
        .req_type(req_type), .req_addr(req_addr), .req_wdata(req_wdata),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .rsp_illegal(rsp_illegal), .rsp_misaligned(rsp_misaligned)
    );

    // Memory model: byte-lane writes, registered word read.
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) begin
                for (int i = 0; i < NB; i++)
                    if (mem_be[i]) dmem[mem_addr[5:0] + 6'(i)] <= mem_wdata[8*i +: 8];
            end else begin
                for (int i = 0; i < NB; i++)
                    mem_rdata[8*i +: 8] <= dmem[mem_addr[5:0] + 6'(i)];
            end
        end
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int ld_bytes(input logic [3:0] t);
        return (t == 4'd8) ? 16 : (1 << t[2:1]);
    endfunction

    // One request, checked in its issue cycle and its response cycle.
    task automatic do_op(input bit st, input logic [3:0] t, input logic [5:0] a,
                         input logic [31:0] d);
        int n;
        bit legal, mis, go;
        logic [3:0]  be_exp;
        logic [31:0] val, wmask, wexp;
        n     = st ? (1 << t) : ld_bytes(t);
        legal = st ? (t <= 4'd2) : (t <= 4'd4);
        mis   = legal && ((int'(a) % n) != 0);
        go    = legal && !mis;
        be_exp = '0;
        wmask  = '0;
        if (go) for (int i = 0; i < n; i++) begin
            be_exp[(int'(a) % 4) + i] = 1'b1;
            wmask[8*((int'(a) % 4) + i) +: 8] = 8'hFF;
        end
        wexp = (d << (8 * (int'(a) % 4))) & wmask;
        val = '0;
        if (!st && go) begin
            for (int i = 0; i < n; i++) val[8*i +: 8] = refm[int'(a) + i];
            if (!t[0] && n < 4 && val[8*n-1]) val = val | ~((32'd1 << (8*n)) - 1);
        end
        @(negedge clk);
        req_valid = 1'b1; req_store = st; req_type = t;
        req_addr = AW'(a); req_wdata = d;
        #1;
        check(st ? (legal ? "R6 mem_en store" : "R4 store legality mem_en")
                 : (legal ? "R6 mem_en load" : "R2 load legality mem_en"),
              64'(mem_en), 64'(go));
        check(legal ? "R3 byte enables" : "R5 illegal byte enables", 64'(mem_be), 64'(be_exp));
        check("R10 write strobe", 64'(mem_we), 64'(go && st));
        check("R10 word address", 64'(mem_addr), 64'({a[5:2], 2'b00}));
        if (st && go) check("R3 store lane data", 64'(mem_wdata & wmask), 64'(wexp));
        @(negedge clk);
        req_valid = 1'b0;
        check("R7 response valid", 64'(rsp_valid), 64'd1);
        check(st ? "R4 illegal flag" : "R5 illegal flag", 64'(rsp_illegal), 64'(!legal));
        check("R6 misaligned flag", 64'(rsp_misaligned), 64'(mis));
        if (st) check("R8 store returns address", 64'(rsp_data), 64'(a));
        else    check("R1 load value", 64'(rsp_data), 64'(val));
        if (st && go) for (int i = 0; i < n; i++) refm[int'(a) + i] = d[8*i +: 8];
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < 64; i++) begin
            dmem[i] = 8'($urandom);
            refm[i] = dmem[i];
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9 reset rsp_valid", 64'(rsp_valid), 64'd0);
        check("R9 reset flags", 64'({rsp_illegal, rsp_misaligned}), 64'd0);
        check("R10 idle mem_en", 64'(mem_en), 64'd0);
        check("R10 idle byte enables", 64'(mem_be), 64'd0);
        rst_n = 1'b1;

        // Directed corner cases.
        do_op(1'b1, 4'd2, 6'd8, 32'h8180_7F01);
        do_op(1'b0, 4'd0, 6'd8, '0);
        do_op(1'b0, 4'd0, 6'd10, '0);
        check("R1 byte sign-extend literal", 64'(rsp_data), 64'hFFFF_FF80);
        do_op(1'b0, 4'd1, 6'd10, '0);
        check("R1 byte zero-extend literal", 64'(rsp_data), 64'h80);
        do_op(1'b0, 4'd2, 6'd10, '0);
        check("R1 half sign-extend literal", 64'(rsp_data), 64'hFFFF_8180);
        do_op(1'b0, 4'd3, 6'd10, '0);
        do_op(1'b0, 4'd4, 6'd8, '0);
        check("R7 word load literal", 64'(rsp_data), 64'h8180_7F01);
        do_op(1'b0, 4'd5, 6'd8, '0);
        do_op(1'b0, 4'd8, 6'd0, '0);
        do_op(1'b1, 4'd3, 6'd8, 32'h1234_5678);
        do_op(1'b1, 4'd1, 6'd9, 32'h0000_BEEF);
        do_op(1'b0, 4'd4, 6'd10, '0);
        do_op(1'b1, 4'd0, 6'd13, 32'h0000_00AB);
        do_op(1'b0, 4'd4, 6'd12, '0);
        do_op(1'b1, 4'd1, 6'd62, 32'hCAFE_F00D);
        do_op(1'b0, 4'd3, 6'd62, '0);

        // Seeded random mix.
        for (int k = 0; k < 600; k++) begin
            bit st;
            logic [3:0] t;
            logic [5:0] a;
            st = 1'($urandom);
            t  = st ? 4'($urandom % 5) : 4'($urandom % 10);
            a  = 6'($urandom);
            if ($urandom % 4 != 0) a = a & ~6'((st ? (1 << t) : ld_bytes(t)) - 1);
            do_op(st, t, a, $urandom);
        end

        // Idle cycle after traffic.
        @(negedge clk);
        check("R10 idle after traffic", 64'({mem_en, mem_we, mem_be}), 64'd0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule